// File: doc/BRIEF.md
# Two-Bank SDRAM Device-Side Read Decoder

This block models the device side of a small two-bank SDRAM. It samples chip select, the row strobe, the column strobe, the write enable and the address bus on every rising clock edge and decodes them into commands. Each bank keeps its open row and an activate-to-read delay counter. A mode word sets the read latency, the burst length and the burst ordering. Reads then produce a timed stream of output beats on a data bus with an output-enable flag.

The data behind each beat comes from a small pattern register file, indexed by bank and column. The open row's low byte is merged into the word so the row tracking can be seen at the pins. Fixed-length bursts release the bus after their last beat unless a new read continues the stream. Full-page bursts wrap around the row and keep going until a terminating command arrives. Illegal activates and reads are rejected, and each one raises a one-cycle error flag. The block can sit beside a controller as an emulator of the memory or as a protocol checker.

Top module: `sdr_rd_dev`

## Requirements
- R1: While `cs_n` is high, the strobes and the address have no effect: no bank opens or closes, no burst starts or stops, the mode is unchanged and `cmd_err` stays low.
- R2: After reset, `dq_oe`, `dq_out` and `cmd_err` are 0, both banks are idle, and the mode is burst length 1, sequential order, latency 2.
- R3: A mode command (`cs_n`,`ras_n`,`cas_n`,`we_n` all low) sets the burst length from `addr[2:0]` (0→1, 1→2, 2→4, 3→8, 7→full page, others→1), the order from `addr[3]` (0 sequential, 1 interleaved) and the latency from `addr[6:4]`. A latency code of 0 or above 3 selects 3. It never raises `cmd_err`.
- R4: Activate (`cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=1) to an idle bank opens row `addr[10:0]` in bank `addr[11]`. Activate to an already open bank raises `cmd_err` for one cycle and leaves the open row unchanged.
- R5: Read (`cs_n`=0, `ras_n`=1, `cas_n`=0, `we_n`=1, `addr[10]`=0) targets bank `addr[11]` at start column `addr[3:0]`. It is accepted only when that bank is open and at least TRCD (default 2) edges have passed since its activate. Otherwise `cmd_err` is high for the one cycle after the command edge and no data follows.
- R6: Let the read be sampled at edge E. The first beat is valid (`dq_oe`=1) from edge E+CL until the next edge, and beat k from edge E+CL+k.
- R7: While `dq_oe` is high, `dq_out` = {open row bits [7:0], 3'b000, bank, column[3:0]}. While `dq_oe` is low, `dq_out` is 0.
- R8: A sequential fixed burst of length BL walks the column upward from the start column and wraps inside the BL-aligned block that holds the start column.
- R9: An interleaved fixed burst gives beat k the column start XOR k.
- R10: A fixed burst gives exactly BL beats, after which `dq_oe` returns low.
- R11: A read accepted in the same cycle that the previous fixed burst issues its last beat continues the output with no idle cycle.
- R12: A full-page burst steps the column upward by one per beat, wraps from 15 to 0 and never ends by itself.
- R13: A burst stop (`ras_n`=1, `cas_n`=1, `we_n`=0), a write (`ras_n`=1, `cas_n`=0, `we_n`=0), a precharge of the burst's bank, or a precharge of all banks, sampled at edge S, ends a read sampled at E after exactly S−E beats. A precharge of the other bank does not end it.
- R14: Precharge (`ras_n`=0, `cas_n`=1, `we_n`=0) closes bank `addr[11]`, or both banks when `addr[10]`=1. A later read to a closed bank is rejected as in R5. Precharge never raises `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (12) | Row, column, bank and mode bits |
| dq_out | output | DW (16) | Read data beat, 0 when not driven |
| dq_oe | output | 1 | Read data valid / output enable |
| cmd_err | output | 1 | One-cycle flag for a rejected activate or read |

## Verification
A corrupted open-row register shows in the upper byte of the first beat, exactly CL cycles after the read. A bad activate-to-read counter shows up one cycle after the command, as an error flag that appears or fails to appear. Beat-counter or ordering faults show as a wrong column nibble on a given beat, or as an output-enable window that is one cycle too long or too short. Latency faults move the whole window, so the bench checks the idle cycle just before the first beat and the one just after the last.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_BST,
        CMD_MRS,
        CMD_REF
    } cmd_e;

endpackage

// File: rtl/sdr_cmd_dec.sv
module sdr_cmd_dec
    import sdr_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = ap ? CMD_NOP : CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
    parameter int COL_W = 4
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [2:0]       bl_code,
    input  logic             interleave,
    output logic [COL_W-1:0] col,
    output logic             last
);

    logic [COL_W-1:0] mask;
    logic             full;

    always_comb begin
        full = (bl_code == 3'd7);
        case (bl_code)
            3'd1:    mask = COL_W'(1);
            3'd2:    mask = COL_W'(3);
            3'd3:    mask = COL_W'(7);
            default: mask = '0;
        endcase
        if (full)
            col = start + beat;
        else if (interleave)
            col = start ^ (beat & mask);
        else
            col = (start & ~mask) | ((start + beat) & mask);
        last = !full && (beat == mask);
    end

endmodule

// File: rtl/sdr_pat_rf.sv
module sdr_pat_rf #(
    parameter int IDX_W = 5,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i);
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sdr_rd_dev.sv
module sdr_rd_dev
    import sdr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 4,
    parameter int DW     = 16,
    parameter int TRCD   = 2,
    parameter int CL_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic              cmd_err
);

    localparam int ROW_W    = ADDR_W - 1;
    localparam int BANK_BIT = ADDR_W - 1;
    localparam int AP_BIT   = ADDR_W - 2;
    localparam int IDX_W    = COL_W + 1;
    localparam int HALF     = DW / 2;
    localparam int CLW      = $clog2(CL_MAX + 1);
    localparam int RCD_W    = $clog2(TRCD + 1);

    typedef struct packed {
        logic             v;
        logic             bank;
        logic [COL_W-1:0] col;
        logic [HALF-1:0]  row;
    } beat_t;

    typedef struct packed {
        logic [2:0]                bl;
        logic                      bt;
        logic [CLW-1:0]            cl;
        logic [1:0]                open;
        logic [1:0][ROW_W-1:0]     row;
        logic [1:0][RCD_W-1:0]     rcd;
        logic                      act;
        logic                      bank;
        logic [COL_W-1:0]          start;
        logic [COL_W-1:0]          beat;
        logic [2:0]                ebl;
        logic                      ebt;
        logic [HALF-1:0]           erow;
        beat_t [CL_MAX-1:0]        pipe;
        logic                      err;
    } st_t;

    st_t              st_q, st_d;
    cmd_e             cmd;
    logic             tgt;
    logic [COL_W-1:0] col_cur;
    logic             last_beat;
    logic [CLW-1:0]   cl_new;
    logic [CLW-1:0]   sel;
    beat_t            out_b;
    logic [DW-1:0]    rf_data;

    assign tgt = addr[BANK_BIT];

    sdr_cmd_dec dec_i (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ap    (addr[AP_BIT]),
        .cmd   (cmd)
    );

    sdr_col_gen #(.COL_W(COL_W)) cg_i (
        .start      (st_q.start),
        .beat       (st_q.beat),
        .bl_code    (st_q.ebl),
        .interleave (st_q.ebt),
        .col        (col_cur),
        .last       (last_beat)
    );

    // latency code from the mode word, out-of-range codes take the longest
    always_comb begin
        if (addr[6:4] == 3'd0 || int'(addr[6:4]) > CL_MAX)
            cl_new = CLW'(CL_MAX);
        else
            cl_new = CLW'(addr[6:4]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        // delay line: the engine's current beat enters stage 0
        st_d.pipe[0].v    = st_q.act;
        st_d.pipe[0].bank = st_q.bank;
        st_d.pipe[0].col  = col_cur;
        st_d.pipe[0].row  = st_q.erow;
        for (int i = 1; i < CL_MAX; i++) st_d.pipe[i] = st_q.pipe[i-1];

        if (st_q.act) begin
            if (last_beat) st_d.act  = 1'b0;
            else           st_d.beat = st_q.beat + 1'b1;
        end

        for (int b = 0; b < 2; b++) begin
            if (st_q.rcd[b] < RCD_W'(TRCD)) st_d.rcd[b] = st_q.rcd[b] + 1'b1;
        end

        case (cmd)
            CMD_ACT: begin
                if (st_q.open[tgt]) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.open[tgt] = 1'b1;
                    st_d.row[tgt]  = addr[ROW_W-1:0];
                    st_d.rcd[tgt]  = RCD_W'(1);
                end
            end
            CMD_RD: begin
                if (!st_q.open[tgt] || st_q.rcd[tgt] < RCD_W'(TRCD)) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.act   = 1'b1;
                    st_d.bank  = tgt;
                    st_d.start = addr[COL_W-1:0];
                    st_d.beat  = '0;
                    st_d.ebl   = st_q.bl;
                    st_d.ebt   = st_q.bt;
                    st_d.erow  = st_q.row[tgt][HALF-1:0];
                end
            end
            CMD_WR, CMD_BST: st_d.act = 1'b0;
            CMD_PRE: begin
                if (addr[AP_BIT]) begin
                    st_d.open = 2'b00;
                    st_d.act  = 1'b0;
                end else begin
                    st_d.open[tgt] = 1'b0;
                    if (st_q.bank == tgt) st_d.act = 1'b0;
                end
            end
            CMD_MRS: begin
                st_d.bl = addr[2:0];
                st_d.bt = addr[3];
                st_d.cl = cl_new;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.cl <= CLW'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign sel   = st_q.cl - 1'b1;
    assign out_b = st_q.pipe[sel];

    sdr_pat_rf #(.IDX_W(IDX_W), .DW(DW)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr ({out_b.bank, out_b.col}),
        .rdata (rf_data)
    );

    assign dq_oe   = out_b.v;
    assign dq_out  = out_b.v ? (rf_data | {out_b.row, {HALF{1'b0}}}) : '0;
    assign cmd_err = st_q.err;

endmodule

// File: rtl/sdr_rd_dev_chk.sv
module sdr_rd_dev_chk #(
    parameter int ADDR_W = 12,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     dq_out,
    input logic              dq_oe,
    input logic              cmd_err
);

    logic is_mrs, is_pre;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == '0); // R7

    AST_DESEL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !cmd_err); // R1

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(!cs_n && we_n && (ras_n != cas_n))); // R5

    AST_MRS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> !cmd_err); // R3

    AST_PRE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> !cmd_err); // R14

endmodule

bind sdr_rd_dev sdr_rd_dev_chk #(.ADDR_W(ADDR_W), .DW(DW)) chk_i (.*);

// File: tb/sdr_rd_dev_tb_top.sv
module sdr_rd_dev_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOGN       = 2048;
    localparam int WD_CYCLES  = 20000;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        cmd_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic        log_oe  [LOGN];
    logic [15:0] log_dq  [LOGN];
    logic        log_err [LOGN];

    sdr_rd_dev dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .addr    (addr),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe),
        .cmd_err (cmd_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < LOGN) begin
            log_oe[cyc]  = dq_oe;
            log_dq[cyc]  = dq_out;
            log_err[cyc] = cmd_err;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic beat(input int idx, input logic [15:0] v, input string req);
        check(log_oe[idx] === 1'b1 && log_dq[idx] === v, req, "beat",
              {15'd0, log_oe[idx], log_dq[idx]}, {16'd1, v});
    endtask

    task automatic quiet(input int idx, input string req);
        check(log_oe[idx] === 1'b0 && log_dq[idx] === 16'h0, req, "idle bus",
              {15'd0, log_oe[idx], log_dq[idx]}, 32'h0);
    endtask

    task automatic errat(input int idx, input logic v, input string req);
        check(log_err[idx] === v, req, "cmd_err", {31'd0, log_err[idx]}, {31'd0, v});
    endtask

    // caller sits at a negedge; command is sampled at edge e
    task automatic send(input logic [3:0] c, input logic [11:0] a, output int e);
        e = cyc + 1;
        {cs_n, ras_n, cas_n, we_n} = c;
        addr = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] a_act(input logic b, input logic [10:0] r);
        return {b, r};
    endfunction

    function automatic logic [11:0] a_rd(input logic b, input logic [3:0] c);
        return {b, 7'b0, c};
    endfunction

    function automatic logic [15:0] word(input logic [7:0] r, input logic b, input logic [3:0] c);
        return {r, 3'b000, b, c};
    endfunction

    task automatic t_reset;
        int e;
        check(dq_oe === 1'b0 && dq_out === 16'h0 && cmd_err === 1'b0, "R2", "reset outputs",
              {15'd0, dq_oe, dq_out}, 32'h0);
        send(C_RD, a_rd(1'b0, 4'd0), e);
        idle(4);
        errat(e, 1'b1, "R5");
        errat(e + 1, 1'b0, "R5");
        quiet(e + 2, "R2");
    endtask

    task automatic t_default;
        int ea, e;
        send(C_ACT, a_act(1'b0, 11'h005), ea);
        idle(1);
        send(C_RD, a_rd(1'b0, 4'd3), e);
        idle(5);
        errat(ea, 1'b0, "R4");
        errat(e, 1'b0, "R5");
        quiet(e + 1, "R6");
        beat(e + 2, word(8'h05, 1'b0, 4'd3), "R2");
        quiet(e + 3, "R10");
    endtask

    task automatic t_rcd;
        int ea, e1, e2;
        send(C_ACT, a_act(1'b1, 11'h0AB), ea);
        send(C_RD, a_rd(1'b1, 4'd9), e1);
        send(C_RD, a_rd(1'b1, 4'd9), e2);
        idle(5);
        errat(e1, 1'b1, "R5");
        errat(e2, 1'b0, "R5");
        quiet(e1 + 2, "R5");
        beat(e2 + 2, word(8'hAB, 1'b1, 4'd9), "R5");
    endtask

    task automatic t_act_busy;
        int e, e2;
        send(C_ACT, a_act(1'b1, 11'h033), e);
        send(C_RD, a_rd(1'b1, 4'd2), e2);
        idle(5);
        errat(e, 1'b1, "R4");
        beat(e2 + 2, word(8'hAB, 1'b1, 4'd2), "R4");
    endtask

    task automatic t_deselect;
        int e1, e2, e3;
        send({1'b1, C_PRE[2:0]}, 12'h400, e1);
        send({1'b1, C_ACT[2:0]}, a_act(1'b1, 11'h044), e2);
        send(C_RD, a_rd(1'b1, 4'd0), e3);
        idle(5);
        errat(e1, 1'b0, "R1");
        errat(e2, 1'b0, "R1");
        errat(e3, 1'b0, "R1");
        beat(e3 + 2, word(8'hAB, 1'b1, 4'd0), "R1");
    endtask

    task automatic t_seq;
        int m, e;
        logic [3:0] cols [4] = '{4'd6, 4'd7, 4'd4, 4'd5};
        send(C_MRS, 12'h032, m);
        send(C_RD, a_rd(1'b0, 4'd6), e);
        idle(9);
        errat(m, 1'b0, "R3");
        quiet(e + 2, "R6");
        for (int k = 0; k < 4; k++) beat(e + 3 + k, word(8'h05, 1'b0, cols[k]), "R8");
        quiet(e + 7, "R10");
    endtask

    task automatic t_inter;
        int m, e;
        send(C_MRS, 12'h02B, m);
        send(C_RD, a_rd(1'b1, 4'd5), e);
        idle(12);
        quiet(e + 1, "R6");
        for (int k = 0; k < 8; k++) beat(e + 2 + k, word(8'hAB, 1'b1, 4'd5 ^ 4'(k)), "R9");
        quiet(e + 10, "R10");
    endtask

    task automatic t_chain;
        int m, e, e2;
        send(C_MRS, 12'h021, m);
        send(C_RD, a_rd(1'b0, 4'd1), e);
        idle(1);
        send(C_RD, a_rd(1'b1, 4'd8), e2);
        idle(8);
        check(e2 == e + 2, "R11", "chain spacing", 32'(e2 - e), 32'd2);
        beat(e + 2, word(8'h05, 1'b0, 4'd1), "R11");
        beat(e + 3, word(8'h05, 1'b0, 4'd0), "R11");
        beat(e + 4, word(8'hAB, 1'b1, 4'd8), "R11");
        beat(e + 5, word(8'hAB, 1'b1, 4'd9), "R11");
        quiet(e + 6, "R10");
    endtask

    task automatic t_full_stop;
        int m, e, s;
        send(C_MRS, 12'h017, m);
        send(C_RD, a_rd(1'b0, 4'd14), e);
        idle(19);
        send(C_BST, 12'h000, s);
        idle(4);
        for (int k = 0; k < s - e; k++) beat(e + 1 + k, word(8'h05, 1'b0, 4'd14 + 4'(k)), "R12");
        quiet(s + 1, "R13");
    endtask

    task automatic t_full_pre;
        int e, p1, p0, e3, e4;
        send(C_RD, a_rd(1'b0, 4'd0), e);
        idle(2);
        send(C_PRE, a_rd(1'b1, 4'd0), p1);
        idle(2);
        send(C_PRE, a_rd(1'b0, 4'd0), p0);
        idle(2);
        send(C_RD, a_rd(1'b0, 4'd0), e3);
        send(C_RD, a_rd(1'b1, 4'd0), e4);
        idle(4);
        errat(p1, 1'b0, "R14");
        errat(p0, 1'b0, "R14");
        for (int k = 0; k < p0 - e; k++) beat(e + 1 + k, word(8'h05, 1'b0, 4'(k)), "R13");
        quiet(p0 + 1, "R13");
        errat(e3, 1'b1, "R14");
        errat(e4, 1'b1, "R14");
        quiet(e4 + 1, "R14");
    endtask

    task automatic t_write_term;
        int ea, e, w;
        send(C_ACT, a_act(1'b0, 11'h07F), ea);
        idle(1);
        send(C_RD, a_rd(1'b0, 4'd2), e);
        idle(3);
        send(C_WR, a_rd(1'b0, 4'd0), w);
        idle(4);
        check(w == e + 4, "R13", "write spacing", 32'(w - e), 32'd4);
        for (int k = 0; k < w - e; k++) beat(e + 1 + k, word(8'h7F, 1'b0, 4'd2 + 4'(k)), "R13");
        quiet(w + 1, "R13");
    endtask

    task automatic t_cl_code;
        int m, e;
        send(C_MRS, 12'h000, m);
        send(C_RD, a_rd(1'b0, 4'd9), e);
        idle(6);
        quiet(e + 2, "R3");
        beat(e + 3, word(8'h7F, 1'b0, 4'd9), "R3");
        quiet(e + 4, "R3");
    endtask

    task automatic t_prea;
        int ea, p, e1, e2;
        send(C_ACT, a_act(1'b1, 11'h001), ea);
        idle(2);
        send(C_PRE, 12'h400, p);
        send(C_RD, a_rd(1'b0, 4'd1), e1);
        send(C_RD, a_rd(1'b1, 4'd1), e2);
        idle(6);
        errat(ea, 1'b0, "R4");
        errat(p, 1'b0, "R14");
        errat(e1, 1'b1, "R14");
        errat(e2, 1'b1, "R14");
        quiet(e1 + 3, "R14");
        quiet(e2 + 3, "R14");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_rcd();
        t_act_busy();
        t_deselect();
        t_seq();
        t_inter();
        t_chain();
        t_full_stop();
        t_full_pre();
        t_write_term();
        t_cl_code();
        t_prea();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): run hung, got %0d cycles expected fewer", WD_CYCLES);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule